// File: doc/BRIEF.md
# Store-Buffered Data Cache Port Arbiter

This block stands between a processor's load/store request port and a single-ported data cache array that always hits. A store is taken at once, confirmed as finished on the next cycle and parked in a small in-order buffer. The array is then free for loads, which go to it in the cycle they arrive. Parked stores are written back to the array one at a time when the array is otherwise idle. Each write-back is a two-cycle read-modify-write of a whole 512-bit line.

A load whose word is still partly or fully in the buffer gets the newest buffered value of each byte. Bytes that no buffered store covers come from the array. So from the core's point of view, every load sees every store accepted before it. The array port is meant to drive a block RAM directly. Address, enable and write data are presented in the cycle of the access. Read data is expected on `arr_rdata` in the cycle after an enabled read (`arr_en` high, `arr_we` low). The buffer depth must be at least 2.

Top module: `stbuf_arbiter`

## Requirements
- R1: A store request with `req_ready` high is accepted, and `st_ack` is high for exactly the following cycle.
- R2: The buffer holds DEPTH (default 8) stores. With DEPTH stores held, `req_ready` is low for a store request and the store is not taken.
- R3: In a cycle with no request, while the buffer is not empty and no write-back is in its second cycle, the array is read (`arr_en`=1, `arr_we`=0) at the line of the oldest buffered store.
- R4: A store arriving while the buffer is already non-empty and idle is buffered, and the read of the oldest entry's line also starts in that same cycle.
- R5: A load (`req_write`=0) is ready unless a write-back is in its second cycle. An accepted load reads its own line from the array in its arrival cycle, ahead of any buffered store. `ld_valid` is high exactly two cycles after acceptance.
- R6: A write-back's second cycle always follows its read cycle. In that cycle the line is written with the oldest store merged in, and that store leaves the buffer. A load offered in that cycle sees `req_ready` low and must wait one cycle.
- R7: `req_size` 0 stores byte `req_wdata[7:0]` to lane `req_addr[1:0]`. Size 1 stores `req_wdata[15:0]` to lanes 0-1 when `req_addr[1]`=0, or to lanes 2-3 when it is 1, and `req_addr[0]` is ignored. Sizes 2 and 3 store the whole word, and `req_addr[1:0]` is ignored. Lane n is bits 8n+7:8n.
- R8: `ld_data` is the full 32-bit word at `req_addr[ADDR_W-1:2]`. Each byte is taken from the youngest buffered store covering it, otherwise from the array.
- R9: For a load, `req_size`, `req_wdata` and `req_addr[1:0]` have no effect on the returned word.
- R10: After reset the buffer is empty, `st_ack`, `ld_valid` and `arr_en` are low, and `req_ready` is high.
- R11: Buffered stores reach the array in acceptance order, so after the buffer drains the array matches the in-order result of all accepted stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Store size: 0 byte, 1 halfword, 2/3 word |
| req_addr | input | ADDR_W (16) | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| st_ack | output | 1 | Store completion pulse |
| ld_valid | output | 1 | Load data valid |
| ld_data | output | 32 | Load data word |
| arr_en | output | 1 | Array access enable |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W-2-log2(LINE_WORDS) (10) | Array line index |
| arr_wdata | output | 32*LINE_WORDS (512) | Line to write |
| arr_rdata | input | 32*LINE_WORDS (512) | Line read, one cycle after the read |

## Verification
A behavioural queue model predicts `req_ready`, the array port activity and the two response pulses on every cycle. A golden word memory gives the value each load must return.

Directed patterns separate the arbitration cases:
- Isolated stores followed by idle cycles show the background drain.
- A load placed right after a drain read lands in the write cycle and exposes the one-cycle hold.
- Long store bursts push the buffer to full and show the refusal.

Stacked byte, halfword and word stores to one word, followed by a load, tell youngest-wins forwarding apart from plain array reads. A long random mix over a few lines stresses forwarding against in-flight write-backs. A final comparison of the whole array against the golden memory checks drain order.

// File: rtl/stb_pkg.sv
package stb_pkg;

  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_MERGE = 1'b1} seq_state_e;

  // byte lanes touched by a store of the given size at the given offset
  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] size,
                                                 input logic [1:0] off);
    case (size)
      2'd0:    lane_mask = 4'b0001 << off;
      2'd1:    lane_mask = off[1] ? 4'b1100 : 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  // replicate right-aligned store data across the lanes it may occupy
  function automatic logic [WORD_W-1:0] lane_data(input logic [1:0] size,
                                                  input logic [WORD_W-1:0] d);
    case (size)
      2'd0:    lane_data = {4{d[7:0]}};
      2'd1:    lane_data = {2{d[15:0]}};
      default: lane_data = d;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] byte_merge(input logic [WORD_W-1:0] base,
                                                   input logic [WORD_W-1:0] over,
                                                   input logic [LANES-1:0]  sel);
    byte_merge = base;
    for (int b = 0; b < LANES; b++)
      if (sel[b]) byte_merge[8*b +: 8] = over[8*b +: 8];
  endfunction

endpackage

// File: rtl/stb_fifo.sv
module stb_fifo #(
  parameter  int DEPTH = 8,
  parameter  int WA_W  = 14,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   push,
  input  logic [WA_W-1:0]        push_wa,
  input  logic [31:0]            push_data,
  input  logic [3:0]             push_mask,
  input  logic                   pop,
  output logic                   full,
  output logic                   empty,
  output logic [WA_W-1:0]        age_wa   [DEPTH],
  output logic [31:0]            age_data [DEPTH],
  output logic [3:0]             age_mask [DEPTH],
  output logic [DEPTH-1:0]       age_live
);

  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;

  logic [WA_W-1:0] wa_q   [DEPTH];
  logic [31:0]     data_q [DEPTH];
  logic [3:0]      mask_q [DEPTH];

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // entry storage, no reset: liveness comes from count
  always_ff @(posedge clk) begin
    if (push) begin
      wa_q[wr_ptr]   <= push_wa;
      data_q[wr_ptr] <= push_data;
      mask_q[wr_ptr] <= push_mask;
    end
  end

  // present entries by age, index 0 = oldest
  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    logic [PTR_W-1:0] slot;
    always_comb begin
      int s;
      s = int'(rd_ptr) + k;
      if (s >= DEPTH) s = s - DEPTH;
      slot = PTR_W'(s);
    end
    assign age_wa[k]   = wa_q[slot];
    assign age_data[k] = data_q[slot];
    assign age_mask[k] = mask_q[slot];
    assign age_live[k] = (CNT_W'(k) < count);
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < CNT_W'(DEPTH)));

  // R11
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));

endmodule

// File: rtl/stb_forward.sv
module stb_forward #(
  parameter int DEPTH = 8,
  parameter int WA_W  = 14
) (
  input  logic [WA_W-1:0]  age_wa   [DEPTH],
  input  logic [31:0]      age_data [DEPTH],
  input  logic [3:0]       age_mask [DEPTH],
  input  logic [DEPTH-1:0] age_live,
  input  logic [WA_W-1:0]  look_wa,
  output logic [3:0]       fwd_mask,
  output logic [31:0]      fwd_data
);

  // oldest to youngest, so later matches override earlier ones per byte
  always_comb begin
    fwd_mask = '0;
    fwd_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (age_live[k] && (age_wa[k] == look_wa)) begin
        for (int b = 0; b < 4; b++) begin
          if (age_mask[k][b]) begin
            fwd_mask[b]        = 1'b1;
            fwd_data[8*b +: 8] = age_data[k][8*b +: 8];
          end
        end
      end
    end
  end

endmodule

// File: rtl/stb_drain_seq.sv
module stb_drain_seq
  import stb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load_go,
  input  logic have_entry,
  output logic drain_rd,
  output logic wr_phase
);

  seq_state_e state_q;

  assign wr_phase = (state_q == SEQ_MERGE);
  assign drain_rd = (state_q == SEQ_IDLE) && have_entry && !load_go;

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEQ_IDLE;
    else     state_q <= drain_rd ? SEQ_MERGE : SEQ_IDLE;
  end

  // R6
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    wr_phase |-> $past(drain_rd));

  // R6
  single_wr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_phase |=> !wr_phase);

endmodule

// File: rtl/stbuf_arbiter.sv
module stbuf_arbiter
  import stb_pkg::*;
#(
  parameter  int ADDR_W     = 16,
  parameter  int LINE_WORDS = 16,
  parameter  int DEPTH      = 8,
  localparam int WA_W       = ADDR_W - 2,
  localparam int OFF_W      = $clog2(LINE_WORDS),
  localparam int LA_W       = WA_W - OFF_W,
  localparam int LINE_W     = 32 * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              st_ack,
  output logic              ld_valid,
  output logic [31:0]       ld_data,
  output logic              arr_en,
  output logic              arr_we,
  output logic [LA_W-1:0]   arr_addr,
  output logic [LINE_W-1:0] arr_wdata,
  input  logic [LINE_W-1:0] arr_rdata
);

  logic [WA_W-1:0] req_wa;
  logic            full, empty;
  logic            ld_go, st_go, drain_rd, wr_phase;
  logic [3:0]      st_mask;
  logic [31:0]     st_data;

  logic [WA_W-1:0]  age_wa   [DEPTH];
  logic [31:0]      age_data [DEPTH];
  logic [3:0]       age_mask [DEPTH];
  logic [DEPTH-1:0] age_live;

  logic [3:0]  fwd_mask;
  logic [31:0] fwd_data;

  assign req_wa    = req_addr[ADDR_W-1:2];
  assign req_ready = req_write ? !full : !wr_phase;
  assign ld_go     = req_valid && !req_write && !wr_phase;
  assign st_go     = req_valid &&  req_write && !full;
  assign st_mask   = lane_mask(req_size, req_addr[1:0]);
  assign st_data   = lane_data(req_size, req_wdata);

  stb_fifo #(.DEPTH(DEPTH), .WA_W(WA_W)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (st_go),
    .push_wa   (req_wa),
    .push_data (st_data),
    .push_mask (st_mask),
    .pop       (wr_phase),
    .full      (full),
    .empty     (empty),
    .age_wa    (age_wa),
    .age_data  (age_data),
    .age_mask  (age_mask),
    .age_live  (age_live)
  );

  stb_forward #(.DEPTH(DEPTH), .WA_W(WA_W)) u_fwd (
    .age_wa   (age_wa),
    .age_data (age_data),
    .age_mask (age_mask),
    .age_live (age_live),
    .look_wa  (req_wa),
    .fwd_mask (fwd_mask),
    .fwd_data (fwd_data)
  );

  stb_drain_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .load_go    (ld_go),
    .have_entry (!empty),
    .drain_rd   (drain_rd),
    .wr_phase   (wr_phase)
  );

  // array port: drain owns it while reading or writing the head line
  logic [WA_W-1:0]  head_wa;
  logic [OFF_W-1:0] head_off;
  logic [31:0]      rd_words [LINE_WORDS];

  assign head_wa  = age_wa[0];
  assign head_off = head_wa[OFF_W-1:0];
  assign arr_en   = ld_go || drain_rd || wr_phase;
  assign arr_we   = wr_phase;
  assign arr_addr = (drain_rd || wr_phase) ? head_wa[WA_W-1:OFF_W]
                                           : req_wa[WA_W-1:OFF_W];

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
    assign rd_words[w] = arr_rdata[32*w +: 32];
    assign arr_wdata[32*w +: 32] = (head_off == OFF_W'(w))
      ? byte_merge(rd_words[w], age_data[0], age_mask[0])
      : rd_words[w];
  end

  // load pipeline: capture forward snapshot, then merge with array word
  logic             l1_v;
  logic [OFF_W-1:0] l1_off;
  logic [3:0]       l1_fmask;
  logic [31:0]      l1_fdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      l1_v     <= 1'b0;
      ld_valid <= 1'b0;
      st_ack   <= 1'b0;
    end else begin
      l1_v     <= ld_go;
      ld_valid <= l1_v;
      st_ack   <= st_go;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_go) begin
      l1_off   <= req_wa[OFF_W-1:0];
      l1_fmask <= fwd_mask;
      l1_fdata <= fwd_data;
    end
    if (l1_v) ld_data <= byte_merge(rd_words[l1_off], l1_fdata, l1_fmask);
  end

  // R1
  store_ack_chk: assert property (@(posedge clk) disable iff (rst)
    st_go |=> st_ack);

  // R5
  load_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    ld_go |=> ##1 ld_valid);

  // R5
  load_port_chk: assert property (@(posedge clk) disable iff (rst)
    ld_go |-> (arr_en && !arr_we && arr_addr == req_wa[WA_W-1:OFF_W]));

  // R6
  load_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && arr_we) |-> !req_ready);

  // R2
  full_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && full) |-> !req_ready);

endmodule

// File: tb/test_stbuf_arbiter.sv
`timescale 1ns/1ps
module test_stbuf_arbiter;

  localparam int ADDR_W = 10;
  localparam int LW     = 16;
  localparam int DEPTH  = 8;
  localparam int NLINE  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]    req_size = '0;
  logic [9:0]    req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          req_ready, st_ack, ld_valid, arr_en, arr_we;
  logic [31:0]   ld_data;
  logic [3:0]    arr_addr;
  logic [511:0]  arr_wdata, arr_rdata;

  stbuf_arbiter #(.ADDR_W(ADDR_W), .LINE_WORDS(LW), .DEPTH(DEPTH)) i_stbuf_arbiter (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .st_ack(st_ack), .ld_valid(ld_valid),
    .ld_data(ld_data), .arr_en(arr_en), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
  );

  function automatic logic [31:0] init_word(input int w);
    logic [7:0] b;
    b = 8'(w);
    return {8'hC3, b, ~b, b ^ 8'h5A};
  endfunction

  // block RAM model
  logic [511:0] mem [NLINE];
  always @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < NLINE; l++)
        for (int w = 0; w < LW; w++) mem[l][32*w +: 32] <= init_word(l*LW + w);
    end else if (arr_en) begin
      if (arr_we) mem[arr_addr] <= arr_wdata;
      else        arr_rdata <= mem[arr_addr];
    end
  end

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  logic [31:0] gold [NLINE*LW];
  int    q_wa[$];
  bit    phase = 1'b0;
  bit    lv_d1 = 0, lv_d2 = 0, sack_d1 = 0;
  logic [31:0] lx_d1, lx_d2;
  string lt_d1 = "R8", lt_d2 = "R8";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] bmask(input logic [1:0] sz, input logic [1:0] off);
    if (sz == 2'd0) return 4'b0001 << off;
    if (sz == 2'd1) return off[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] apply(input logic [31:0] old, input logic [1:0] sz,
                                        input logic [1:0] off, input logic [31:0] d);
    logic [31:0] r;
    logic [3:0]  m;
    r = old;
    m = bmask(sz, off);
    for (int b = 0; b < 4; b++) begin
      if (m[b]) begin
        if (sz == 2'd0)      r[8*b +: 8] = d[7:0];
        else if (sz == 2'd1) r[8*b +: 8] = d[8*(b%2) +: 8];
        else                 r[8*b +: 8] = d[8*b +: 8];
      end
    end
    return r;
  endfunction

  // one cycle: drive at negedge, compare, advance model at posedge
  task automatic step(input bit v, input bit wr, input logic [1:0] sz,
                      input logic [9:0] a, input logic [31:0] d, input string ltag);
    bit er, lgo, sgo, drd;
    int wa;
    logic [3:0] eline;
    req_valid = v; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
    wa = int'(a[9:2]);
    #1;
    er = wr ? (q_wa.size() < DEPTH) : !phase;
    if (v) chk(wr ? "R2 ready" : "R6 ready", 32'(req_ready), 32'(er));
    lgo = v && !wr && er;
    sgo = v && wr && er;
    drd = !phase && (q_wa.size() > 0) && !lgo;
    chk(lgo ? "R5 en" : (phase ? "R6 en" : (sgo && drd ? "R4 en" : "R3 en")),
        32'(arr_en), 32'(lgo || drd || phase));
    chk(phase ? "R6 we" : "R5 we", 32'(arr_we), 32'(phase));
    if (lgo || drd || phase) begin
      eline = (drd || phase) ? 4'(q_wa[0] >> 4) : a[9:6];
      chk(lgo ? "R5 addr" : (sgo ? "R4 addr" : "R3 addr"), 32'(arr_addr), 32'(eline));
    end
    chk("R1 ack", 32'(st_ack), 32'(sack_d1));
    chk("R5 valid", 32'(ld_valid), 32'(lv_d2));
    if (lv_d2) chk(lt_d2, ld_data, lx_d2);
    @(posedge clk);
    lv_d2 = lv_d1; lx_d2 = lx_d1; lt_d2 = lt_d1;
    lv_d1 = lgo;
    if (lgo) begin lx_d1 = gold[wa]; lt_d1 = ltag; end
    sack_d1 = sgo;
    if (phase) begin void'(q_wa.pop_front()); phase = 1'b0; end
    else if (drd) phase = 1'b1;
    if (sgo) begin
      q_wa.push_back(wa);
      gold[wa] = apply(gold[wa], sz, a[1:0], d);
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 2'd0, 10'd0, 32'd0, "R8");
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < NLINE*LW; w++) gold[w] = init_word(w);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R10 reset state
    chk("R10 ready", 32'(req_ready), 32'd1);
    chk("R10 ld_valid", 32'(ld_valid), 32'd0);
    chk("R10 st_ack", 32'(st_ack), 32'd0);
    chk("R10 arr_en", 32'(arr_en), 32'd0);
    @(negedge clk);

    // R5 plain load, array only
    step(1, 0, 2'd2, {8'd20, 2'd0}, 32'd0, "R5 data");
    idle(3);

    // R1/R3 isolated store, then drain; R6 load lands in write cycle
    step(1, 1, 2'd2, {8'd5, 2'd0}, 32'hDEAD_BEEF, "R8");
    step(0, 0, 2'd0, 10'd0, 32'd0, "R8");                       // drain read
    step(1, 0, 2'd2, {8'd5, 2'd0}, 32'd0, "R6 data");           // refused
    step(1, 0, 2'd2, {8'd5, 2'd0}, 32'd0, "R6 data");           // accepted
    idle(3);

    // R7 byte, halfword with odd address, word ignoring offset; loads forward
    step(1, 1, 2'd0, {8'd40, 2'd2}, 32'hFFFF_FF11, "R8");
    step(1, 0, 2'd2, {8'd40, 2'd0}, 32'd0, "R7 byte fwd");
    step(1, 1, 2'd1, {8'd41, 2'd3}, 32'hAAAA_2233, "R8");
    step(1, 0, 2'd2, {8'd41, 2'd0}, 32'd0, "R7 half fwd");
    step(1, 1, 2'd3, {8'd42, 2'd1}, 32'h0102_0304, "R8");
    step(1, 0, 2'd0, {8'd42, 2'd3}, 32'hFFFF_FFFF, "R9 ignore");
    idle(10);
    step(1, 0, 2'd1, {8'd40, 2'd1}, 32'h1234_5678, "R7 byte array");
    idle(3);

    // R8 youngest wins: word, then two bytes on the same lane, then half
    step(1, 1, 2'd2, {8'd60, 2'd0}, 32'h1111_1111, "R8");
    step(1, 1, 2'd0, {8'd60, 2'd1}, 32'h0000_00A1, "R8");
    step(1, 1, 2'd0, {8'd60, 2'd1}, 32'h0000_00B2, "R8");
    step(1, 1, 2'd1, {8'd60, 2'd2}, 32'h0000_C3D4, "R8");
    step(1, 0, 2'd2, {8'd60, 2'd0}, 32'd0, "R8 youngest");
    step(1, 0, 2'd2, {8'd61, 2'd0}, 32'd0, "R8 other word");
    idle(12);

    // R2/R4 long store burst fills the buffer
    for (int i = 0; i < 24; i++)
      step(1, 1, 2'(i % 4), {8'(64 + i % 6), 2'(i)}, 32'h5000_0000 + 32'(i * 97), "R8");
    step(1, 0, 2'd2, {8'd66, 2'd0}, 32'd0, "R8 after burst");
    idle(24);

    // random mix over a few lines
    for (int i = 0; i < 800; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 4)
        step(1, 1, 2'($urandom_range(0, 3)), {8'($urandom_range(0, 47)), 2'($urandom_range(0, 3))},
             32'($urandom), "R8");
      else if (r < 7)
        step(1, 0, 2'($urandom_range(0, 3)), {8'($urandom_range(0, 47)), 2'($urandom_range(0, 3))},
             32'($urandom), "R8 random");
      else
        step(0, 0, 2'd0, 10'd0, 32'd0, "R8");
    end
    idle(30);

    // R11 array content after full drain
    for (int l = 0; l < NLINE; l++)
      for (int w = 0; w < LW; w++)
        chk("R11 array", mem[l][32*w +: 32], gold[l*LW + w]);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule